// File: doc/BRIEF.md
# PC Card Byte-Lane Steering Unit

This unit sits between a 16-bit PC Card host bus and a card-internal memory built from a pair of byte-wide devices. One device holds the even bytes and the other holds the odd bytes. A separate byte-wide attribute store holds configuration data. For every cycle, the unit decodes the two active-low card enables into an access kind: standby, byte, word or odd-byte-only. The attribute-plane select and the low address bit then choose which stored byte is meant.

For reads, the unit puts the chosen even or odd byte onto the correct host data lane. It also produces one output enable per lane, so that an external pad stage drives only the lanes in use. An 8-bit host reaches odd bytes by asserting only the low-lane enable and setting the address bit high. The odd byte then arrives on the low lane. The attribute plane has only even bytes, so any lane that would carry an odd attribute byte returns all ones.

For writes, the unit raises one write strobe per device and routes the host lanes to the matching device data inputs. This includes moving a low-lane byte to the odd device. The host wait line is held inactive at all times.

Results are registered, so lane data, lane use and strobes reflect the inputs of the previous clock. The lane output enables are also gated directly by the current output-enable and write-enable levels, so a read releases the bus in the same cycle the host ends it.

Top module: `pccard_lane_steer`

## Requirements
- R1: While `rst` is high and on the first sample after it, `host_rdata` is 16'h0000 and both lane output enables and all three write strobes are 0.
- R2: With both card enables high (standby), neither lane output enable nor any write strobe rises, for read or write cycles.
- R3: Byte read (`host_ce_lo_n`=0, `host_ce_hi_n`=1, common plane): one clock later `host_lo_oe`=1 and `host_rdata[7:0]` is the even byte when `host_a0`=0 and the odd byte when `host_a0`=1; `host_hi_oe`=0.
- R4: Word read (both enables low, common plane): one clock later both lane enables are 1, `host_rdata[7:0]` is the even byte and `host_rdata[15:8]` the odd byte, whatever `host_a0` is.
- R5: Odd-only read (`host_ce_lo_n`=1, `host_ce_hi_n`=0): one clock later `host_hi_oe`=1 with the odd byte on `host_rdata[15:8]`, and `host_lo_oe`=0.
- R6: Attribute reads (`host_reg_n`=0) place `attr_rdata` on the low lane for a byte access with `host_a0`=0 and for a word access; a byte access with `host_a0`=1, the upper lane of a word access and an odd-only access return 8'hFF.
- R7: A lane output enable is 1 only while `host_oe_n`=0 and `host_we_n`=1. It falls in the same cycle `host_oe_n` rises, and a read first drives one clock after it starts.
- R8: Byte write (`host_oe_n`=1, `host_we_n`=0, common plane): with `host_a0`=0 only `arr_even_we` rises, carrying `host_wdata[7:0]`; with `host_a0`=1 only `arr_odd_we` rises, and `arr_odd_wdata` takes `host_wdata[7:0]`.
- R9: Word write raises both device strobes, with the even data from `host_wdata[7:0]` and the odd data from `host_wdata[15:8]`; odd-only write raises only `arr_odd_we`, carrying `host_wdata[15:8]`.
- R10: Attribute writes raise only `attr_we` (data `host_wdata[7:0]`) for a byte access with `host_a0`=0 or a word access. An attribute write to an odd byte raises no strobe, and the device strobes never rise when `host_reg_n`=0.
- R11: `host_wait_n` is 1 at all times.
- R12: A cycle with both `host_oe_n` and `host_we_n` low neither drives a lane nor raises a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_ce_lo_n | input | 1 | Low-lane (even byte) card enable, active low |
| host_ce_hi_n | input | 1 | High-lane (odd byte) card enable, active low |
| host_a0 | input | 1 | Host address bit 0 (byte select) |
| host_oe_n | input | 1 | Host output enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| host_reg_n | input | 1 | Attribute plane select, active low |
| host_wdata | input | 16 | Host write data, both lanes |
| arr_even_rdata | input | 8 | Read data from even-byte device |
| arr_odd_rdata | input | 8 | Read data from odd-byte device |
| attr_rdata | input | 8 | Read data from attribute store |
| host_rdata | output | 16 | Read data for the host lanes |
| host_lo_oe | output | 1 | Drive enable for host lane 7..0 |
| host_hi_oe | output | 1 | Drive enable for host lane 15..8 |
| host_wait_n | output | 1 | Wait line, held inactive |
| arr_even_we | output | 1 | Even device write strobe |
| arr_odd_we | output | 1 | Odd device write strobe |
| attr_we | output | 1 | Attribute store write strobe |
| arr_even_wdata | output | 8 | Even device write data |
| arr_odd_wdata | output | 8 | Odd device write data |
| attr_wdata | output | 8 | Attribute store write data |

## Verification
A read's lane drive and a write's strobe are the two functions that could meet in one cycle. This happens when the host pulls output enable and write enable low together, and also at the turn from a write cycle into a read cycle. The bench drives a word access with both enables low and expects no lane enable and no strobe. It also ends a read by raising output enable between clock edges and checks that the lane enables drop before the next edge. A checker additionally forbids any cycle with a lane enable and a strobe both high.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
  typedef enum logic [1:0] {
    ACC_IDLE = 2'd0,
    ACC_BYTE = 2'd1,
    ACC_WORD = 2'd2,
    ACC_ODD  = 2'd3
  } acc_kind_t;
endpackage

// File: rtl/pcl_decode.sv
module pcl_decode
  import pcl_pkg::*;
(
  input  logic      ce_lo_n,
  input  logic      ce_hi_n,
  input  logic      oe_n,
  input  logic      we_n,
  output acc_kind_t kind,
  output logic      rd,
  output logic      wr
);
  always_comb begin
    unique case ({ce_hi_n, ce_lo_n})
      2'b11:   kind = ACC_IDLE;
      2'b10:   kind = ACC_BYTE;
      2'b00:   kind = ACC_WORD;
      default: kind = ACC_ODD;
    endcase
  end

  assign rd = (kind != ACC_IDLE) && !oe_n && we_n;
  assign wr = (kind != ACC_IDLE) && oe_n && !we_n;
endmodule

// File: rtl/pcl_read_steer.sv
module pcl_read_steer
  import pcl_pkg::*;
#(
  parameter int unsigned        LANE_W       = 8,
  parameter logic [LANE_W-1:0]  INVALID_BYTE = '1
) (
  input  acc_kind_t           kind,
  input  logic                a0,
  input  logic                attr_sel,
  input  logic [LANE_W-1:0]   even_rd,
  input  logic [LANE_W-1:0]   odd_rd,
  input  logic [LANE_W-1:0]   attr_rd,
  output logic [LANE_W-1:0]   lo_d,
  output logic [LANE_W-1:0]   hi_d,
  output logic                lo_use,
  output logic                hi_use
);
  logic [LANE_W-1:0] src_even;
  logic [LANE_W-1:0] src_odd;

  // Attribute plane: only even bytes exist; odd positions read as fill.
  assign src_even = attr_sel ? attr_rd      : even_rd;
  assign src_odd  = attr_sel ? INVALID_BYTE : odd_rd;

  assign lo_use = (kind == ACC_BYTE) || (kind == ACC_WORD);
  assign hi_use = (kind == ACC_WORD) || (kind == ACC_ODD);

  always_comb begin
    if (kind == ACC_BYTE && a0) lo_d = src_odd;
    else                        lo_d = src_even;
  end

  assign hi_d = src_odd;
endmodule

// File: rtl/pcl_write_steer.sv
module pcl_write_steer
  import pcl_pkg::*;
#(
  parameter int unsigned LANE_W = 8
) (
  input  acc_kind_t          kind,
  input  logic               a0,
  input  logic               attr_sel,
  input  logic               wr,
  input  logic [LANE_W-1:0]  lo_wd,
  input  logic [LANE_W-1:0]  hi_wd,
  output logic               even_we,
  output logic               odd_we,
  output logic               attr_we,
  output logic [LANE_W-1:0]  even_wd,
  output logic [LANE_W-1:0]  odd_wd,
  output logic [LANE_W-1:0]  attr_wd
);
  logic even_hit;
  logic odd_hit;

  assign even_hit = ((kind == ACC_BYTE) && !a0) || (kind == ACC_WORD);
  assign odd_hit  = ((kind == ACC_BYTE) && a0) || (kind == ACC_WORD) || (kind == ACC_ODD);

  assign even_we = wr && !attr_sel && even_hit;
  assign odd_we  = wr && !attr_sel && odd_hit;
  assign attr_we = wr && attr_sel && even_hit;

  // An 8-bit host delivers the odd byte on the low lane.
  assign even_wd = lo_wd;
  assign odd_wd  = (kind == ACC_BYTE) ? lo_wd : hi_wd;
  assign attr_wd = lo_wd;
endmodule

// File: rtl/pccard_lane_steer.sv
module pccard_lane_steer
  import pcl_pkg::*;
#(
  parameter int unsigned       LANE_W       = 8,
  parameter logic [LANE_W-1:0] INVALID_BYTE = '1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  host_ce_lo_n,
  input  logic                  host_ce_hi_n,
  input  logic                  host_a0,
  input  logic                  host_oe_n,
  input  logic                  host_we_n,
  input  logic                  host_reg_n,
  input  logic [2*LANE_W-1:0]   host_wdata,
  input  logic [LANE_W-1:0]     arr_even_rdata,
  input  logic [LANE_W-1:0]     arr_odd_rdata,
  input  logic [LANE_W-1:0]     attr_rdata,
  output logic [2*LANE_W-1:0]   host_rdata,
  output logic                  host_lo_oe,
  output logic                  host_hi_oe,
  output logic                  host_wait_n,
  output logic                  arr_even_we,
  output logic                  arr_odd_we,
  output logic                  attr_we,
  output logic [LANE_W-1:0]     arr_even_wdata,
  output logic [LANE_W-1:0]     arr_odd_wdata,
  output logic [LANE_W-1:0]     attr_wdata
);
  localparam int unsigned LANES = 2;

  acc_kind_t         kind;
  logic              rd;
  logic              wr;
  logic              attr_sel;
  logic [LANE_W-1:0] lane_d   [LANES];
  logic [LANES-1:0]  lane_use;
  logic [LANES-1:0]  lane_en_q;
  logic [LANE_W-1:0] lane_q   [LANES];
  logic              reading_now;
  logic              even_we_c, odd_we_c, attr_we_c;
  logic [LANE_W-1:0] even_wd_c, odd_wd_c, attr_wd_c;

  assign attr_sel = !host_reg_n;

  pcl_decode u_decode (
    .ce_lo_n (host_ce_lo_n),
    .ce_hi_n (host_ce_hi_n),
    .oe_n    (host_oe_n),
    .we_n    (host_we_n),
    .kind    (kind),
    .rd      (rd),
    .wr      (wr)
  );

  pcl_read_steer #(.LANE_W(LANE_W), .INVALID_BYTE(INVALID_BYTE)) u_rd (
    .kind     (kind),
    .a0       (host_a0),
    .attr_sel (attr_sel),
    .even_rd  (arr_even_rdata),
    .odd_rd   (arr_odd_rdata),
    .attr_rd  (attr_rdata),
    .lo_d     (lane_d[0]),
    .hi_d     (lane_d[1]),
    .lo_use   (lane_use[0]),
    .hi_use   (lane_use[1])
  );

  pcl_write_steer #(.LANE_W(LANE_W)) u_wr (
    .kind     (kind),
    .a0       (host_a0),
    .attr_sel (attr_sel),
    .wr       (wr),
    .lo_wd    (host_wdata[LANE_W-1:0]),
    .hi_wd    (host_wdata[2*LANE_W-1:LANE_W]),
    .even_we  (even_we_c),
    .odd_we   (odd_we_c),
    .attr_we  (attr_we_c),
    .even_wd  (even_wd_c),
    .odd_wd   (odd_wd_c),
    .attr_wd  (attr_wd_c)
  );

  // Per-lane read registers; drive release is gated by the live strobes.
  assign reading_now = !host_oe_n && host_we_n;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        lane_en_q[g] <= 1'b0;
        lane_q[g]    <= '0;
      end else begin
        lane_en_q[g] <= rd && lane_use[g];
        if (rd && lane_use[g]) lane_q[g] <= lane_d[g];
      end
    end
    assign host_rdata[g*LANE_W +: LANE_W] = lane_q[g];
  end

  assign host_lo_oe = lane_en_q[0] && reading_now;
  assign host_hi_oe = lane_en_q[1] && reading_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      arr_even_we    <= 1'b0;
      arr_odd_we     <= 1'b0;
      attr_we        <= 1'b0;
      arr_even_wdata <= '0;
      arr_odd_wdata  <= '0;
      attr_wdata     <= '0;
    end else begin
      arr_even_we <= even_we_c;
      arr_odd_we  <= odd_we_c;
      attr_we     <= attr_we_c;
      if (even_we_c) arr_even_wdata <= even_wd_c;
      if (odd_we_c)  arr_odd_wdata  <= odd_wd_c;
      if (attr_we_c) attr_wdata     <= attr_wd_c;
    end
  end

  assign host_wait_n = 1'b1;
endmodule

// File: rtl/pccard_lane_steer_chk.sv
module pccard_lane_steer_chk (
  input logic clk,
  input logic rst,
  input logic host_ce_lo_n,
  input logic host_ce_hi_n,
  input logic host_oe_n,
  input logic host_we_n,
  input logic host_reg_n,
  input logic host_lo_oe,
  input logic host_hi_oe,
  input logic arr_even_we,
  input logic arr_odd_we,
  input logic attr_we
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  AST_STANDBY_QUIET: assert property (@(posedge clk) disable iff (rst || !armed)
    (host_ce_lo_n && host_ce_hi_n) |=>
      !(arr_even_we || arr_odd_we || attr_we || host_lo_oe || host_hi_oe)); // R2

  AST_ODD_ONLY_LOW_IDLE: assert property (@(posedge clk) disable iff (rst || !armed)
    (host_ce_lo_n && !host_ce_hi_n) |=> !(host_lo_oe || arr_even_we || attr_we)); // R5

  AST_RELEASE_ON_OE: assert property (@(posedge clk) disable iff (rst || !armed)
    (host_oe_n || !host_we_n) |-> !(host_lo_oe || host_hi_oe)); // R7

  AST_ATTR_NO_DEVICE: assert property (@(posedge clk) disable iff (rst || !armed)
    !host_reg_n |=> !(arr_even_we || arr_odd_we)); // R10

  AST_NO_DRIVE_WITH_STROBE: assert property (@(posedge clk) disable iff (rst || !armed)
    (host_lo_oe || host_hi_oe) |-> !(arr_even_we || arr_odd_we || attr_we)); // R12

  AST_CONFLICT_QUIET: assert property (@(posedge clk) disable iff (rst || !armed)
    (!host_oe_n && !host_we_n) |=> !(arr_even_we || arr_odd_we || attr_we)); // R12
endmodule

bind pccard_lane_steer pccard_lane_steer_chk u_chk (.*);

// File: tb/pccard_lane_steer_test.sv
module pccard_lane_steer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_lo_n = 1'b1, ce_hi_n = 1'b1, a0 = 1'b0;
  logic        oe_n = 1'b1, we_n = 1'b1, reg_n = 1'b1;
  logic [15:0] wdata = '0;
  logic [7:0]  even_rd = 8'h3C, odd_rd = 8'hA5, attr_rd = 8'h5E;
  logic [15:0] rdata;
  logic        lo_oe, hi_oe, wait_n, e_we, o_we, a_we;
  logic [7:0]  e_wd, o_wd, a_wd;
  int          nchk = 0;
  int          nfail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pccard_lane_steer uut (
    .clk(clk), .rst(rst), .host_ce_lo_n(ce_lo_n), .host_ce_hi_n(ce_hi_n),
    .host_a0(a0), .host_oe_n(oe_n), .host_we_n(we_n), .host_reg_n(reg_n),
    .host_wdata(wdata), .arr_even_rdata(even_rd), .arr_odd_rdata(odd_rd),
    .attr_rdata(attr_rd), .host_rdata(rdata), .host_lo_oe(lo_oe),
    .host_hi_oe(hi_oe), .host_wait_n(wait_n), .arr_even_we(e_we),
    .arr_odd_we(o_we), .attr_we(a_we), .arr_even_wdata(e_wd),
    .arr_odd_wdata(o_wd), .attr_wdata(a_wd)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive a cycle at a falling edge, let one rising edge capture it, sample at the next falling edge.
  task automatic step(input logic cl, input logic ch, input logic ad, input logic o,
                      input logic w, input logic r, input logic [15:0] d);
    @(negedge clk);
    ce_lo_n = cl; ce_hi_n = ch; a0 = ad; oe_n = o; we_n = w; reg_n = r; wdata = d;
    @(negedge clk);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 rdata in reset", rdata, 16'h0);
    chk("R1 lane enables in reset", {14'h0, lo_oe, hi_oe}, 16'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 strobes after reset", {13'h0, e_we, o_we, a_we}, 16'h0);
    chk("R11 wait held high", {15'h0, wait_n}, 16'h1);
  endtask

  task automatic t_standby;
    step(1, 1, 0, 0, 1, 1, 16'h0);
    chk("R2 standby read lanes", {14'h0, lo_oe, hi_oe}, 16'h0);
    step(1, 1, 1, 1, 0, 1, 16'hFFFF);
    chk("R2 standby write strobes", {13'h0, e_we, o_we, a_we}, 16'h0);
  endtask

  task automatic t_byte_read;
    step(0, 1, 0, 0, 1, 1, 16'h0);
    chk("R3 byte even enables", {14'h0, lo_oe, hi_oe}, 16'h2);
    chk("R3 byte even data", {8'h0, rdata[7:0]}, 16'h003C);
    step(0, 1, 1, 0, 1, 1, 16'h0);
    chk("R3 byte odd enables", {14'h0, lo_oe, hi_oe}, 16'h2);
    chk("R3 byte odd data on low lane", {8'h0, rdata[7:0]}, 16'h00A5);
  endtask

  task automatic t_word_read;
    step(0, 0, 0, 0, 1, 1, 16'h0);
    chk("R4 word enables a0=0", {14'h0, lo_oe, hi_oe}, 16'h3);
    chk("R4 word data a0=0", rdata, 16'hA53C);
    even_rd = 8'h81; odd_rd = 8'h7E;
    step(0, 0, 1, 0, 1, 1, 16'h0);
    chk("R4 word data a0=1", rdata, 16'h7E81);
    even_rd = 8'h3C; odd_rd = 8'hA5;
  endtask

  task automatic t_odd_read;
    step(1, 0, 0, 0, 1, 1, 16'h0);
    chk("R5 odd-only enables", {14'h0, lo_oe, hi_oe}, 16'h1);
    chk("R5 odd-only data", {8'h0, rdata[15:8]}, 16'h00A5);
  endtask

  task automatic t_attr_read;
    step(0, 1, 0, 0, 1, 0, 16'h0);
    chk("R6 attr byte even", {8'h0, rdata[7:0]}, 16'h005E);
    step(0, 1, 1, 0, 1, 0, 16'h0);
    chk("R6 attr byte odd invalid", {8'h0, rdata[7:0]}, 16'h00FF);
    step(0, 0, 0, 0, 1, 0, 16'h0);
    chk("R6 attr word lanes", rdata, 16'hFF5E);
    chk("R6 attr word enables", {14'h0, lo_oe, hi_oe}, 16'h3);
    step(1, 0, 0, 0, 1, 0, 16'h0);
    chk("R6 attr odd-only invalid", {8'h0, rdata[15:8]}, 16'h00FF);
  endtask

  task automatic t_oe_timing;
    step(1, 1, 0, 1, 1, 1, 16'h0);
    @(negedge clk);
    ce_lo_n = 0; ce_hi_n = 0; oe_n = 0; we_n = 1; reg_n = 1;
    #1;
    chk("R7 no drive before first edge", {14'h0, lo_oe, hi_oe}, 16'h0);
    @(negedge clk);
    chk("R7 drive after one edge", {14'h0, lo_oe, hi_oe}, 16'h3);
    oe_n = 1;
    #1;
    chk("R7 release same cycle OE rises", {14'h0, lo_oe, hi_oe}, 16'h0);
  endtask

  task automatic t_byte_write;
    step(0, 1, 0, 1, 0, 1, 16'h1234);
    chk("R8 byte even strobes", {13'h0, e_we, o_we, a_we}, 16'h4);
    chk("R8 byte even data", {8'h0, e_wd}, 16'h0034);
    step(0, 1, 1, 1, 0, 1, 16'h9A77);
    chk("R8 byte odd strobes", {13'h0, e_we, o_we, a_we}, 16'h2);
    chk("R8 byte odd data from low lane", {8'h0, o_wd}, 16'h0077);
  endtask

  task automatic t_word_odd_write;
    step(0, 0, 1, 1, 0, 1, 16'hBEEF);
    chk("R9 word strobes", {13'h0, e_we, o_we, a_we}, 16'h6);
    chk("R9 word data", {o_wd, e_wd}, 16'hBEEF);
    step(1, 0, 0, 1, 0, 1, 16'hC3D2);
    chk("R9 odd-only strobes", {13'h0, e_we, o_we, a_we}, 16'h2);
    chk("R9 odd-only data", {8'h0, o_wd}, 16'h00C3);
  endtask

  task automatic t_attr_write;
    step(0, 1, 0, 1, 0, 0, 16'h0011);
    chk("R10 attr byte even strobes", {13'h0, e_we, o_we, a_we}, 16'h1);
    chk("R10 attr data", {8'h0, a_wd}, 16'h0011);
    step(0, 1, 1, 1, 0, 0, 16'h0022);
    chk("R10 attr byte odd no strobe", {13'h0, e_we, o_we, a_we}, 16'h0);
    step(1, 0, 0, 1, 0, 0, 16'h3300);
    chk("R10 attr odd-only no strobe", {13'h0, e_we, o_we, a_we}, 16'h0);
    step(0, 0, 0, 1, 0, 0, 16'h6644);
    chk("R10 attr word strobes", {13'h0, e_we, o_we, a_we}, 16'h1);
    chk("R10 attr word data", {8'h0, a_wd}, 16'h0044);
  endtask

  task automatic t_conflict;
    step(0, 0, 0, 0, 0, 1, 16'hAAAA);
    chk("R12 conflict strobes", {13'h0, e_we, o_we, a_we}, 16'h0);
    chk("R12 conflict lanes", {14'h0, lo_oe, hi_oe}, 16'h0);
    chk("R11 wait still high", {15'h0, wait_n}, 16'h1);
  endtask

  initial begin
    t_reset();
    t_standby();
    t_byte_read();
    t_word_read();
    t_odd_read();
    t_attr_read();
    t_oe_timing();
    t_byte_write();
    t_word_odd_write();
    t_attr_write();
    t_conflict();
    step(1, 1, 0, 1, 1, 1, 16'h0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule